// File: doc/BRIEF.md
# Multiplexer-Layered Right Rotator

This block turns a 16-bit data word to the right by a 4-bit count, which can be anything from 0 to 15. Any bit pushed out past the least significant position comes back in at the most significant end, so no bit is lost and no fill value is needed. The output depends only on the present inputs. There is no clock, no reset and no stored state, so a designer can drop the block into any datapath between registers.

The rotation is split into four fixed layers, applied in order. Layer k either passes its word through or turns it right by 2^k places. The choice is made by bit k of the count. Each layer's fixed turn is pure rewiring of bit indices feeding a 2:1 multiplexer per bit. No shift or rotate operator is used anywhere in the design.

Top module: `ring_rotate_right`

## Requirements
- R1: The data input is 16 bits wide (bit 0 least significant, bit 15 most significant) and the count input is 4 bits wide; every count from 0 to 15 is accepted.
- R2: Rotation moves bits toward bit 0 and never creates or destroys a bit: the output has the same number of ones as the input.
- R3: A bit leaving bit 0 re-enters at bit 15; in general input bit 0 lands at output position (16 − count) mod 16.
- R4: For every count B and word A the output equals (A >> B) | (A << (16 − B)) truncated to 16 bits.
- R5: A count of 0 gives an output identical to the input, and each layer whose select bit is 0 passes its word unchanged.
- R6: Word 16'hB573 (1011010101110011) turned by 5 gives 16'h9DAB (1001110110101011).
- R7: A count with only bit k set turns the word by exactly 2^k places, for k = 0 to 3.
- R8: The all-zero and all-one words come out unchanged for every count.
- R9: The output follows the inputs combinationally, with no clock or latency: a new input pair is reflected in the output within the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| din  | input  | 16 | Word to be rotated |
| amt  | input  | 4  | Rotation count toward bit 0 |
| dout | output | 16 | Rotated word |

## Verification
Every result is due in the same cycle as its stimulus, because the block holds no registers. The bench applies a new word and count just after a rising clock edge. It then compares the output with its reference at the following falling edge, half a period later, once the combinational path has settled. The reference is a behavioural doubled-word shift, checked against every one of the 16 counts with thousands of random words. The edge words and the worked example are also checked at every count.

// File: rtl/rot_pkg.sv
package rot_pkg;
    parameter int unsigned ROT_WIDTH = 16;
    localparam int unsigned ROT_AMT_W = $clog2(ROT_WIDTH);
    typedef logic [ROT_WIDTH-1:0] rot_word_t;
    typedef logic [ROT_AMT_W-1:0] rot_amt_t;
endpackage

// File: rtl/rot_stage.sv
module rot_stage #(
    parameter int unsigned WIDTH = 16,
    parameter int unsigned DIST  = 1
) (
    input  logic [WIDTH-1:0] stage_in,
    input  logic             sel,
    output logic [WIDTH-1:0] stage_out
);
    logic [WIDTH-1:0] turned;

    // fixed rewiring: output bit i takes input bit (i + DIST) mod WIDTH
    for (genvar i = 0; i < WIDTH; i++) begin : g_wire
        localparam int unsigned SRC = (i + DIST) % WIDTH;
        assign turned[i] = stage_in[SRC];
    end

    always_comb begin
        stage_out = sel ? turned : stage_in;
    end

    always_comb begin
        if (!$isunknown({stage_in, sel})) begin
            assert_layer_hold_R5: assert (sel || stage_out == stage_in)
                else $error("layer with select low altered its word");
            assert_layer_ones_R2: assert ($countones(stage_out) == $countones(stage_in))
                else $error("layer changed the count of ones");
        end
    end
endmodule

// File: rtl/rot_core.sv
module rot_core #(
    parameter int unsigned WIDTH = 16,
    parameter int unsigned AMT_W = $clog2(WIDTH)
) (
    input  logic [WIDTH-1:0] core_in,
    input  logic [AMT_W-1:0] core_amt,
    output logic [WIDTH-1:0] core_out
);
    logic [WIDTH-1:0] chain [0:AMT_W];

    assign chain[0] = core_in;

    // layer k turns by 2**k when core_amt[k] is set, applied k = 0 upward
    for (genvar k = 0; k < AMT_W; k++) begin : g_layer
        rot_stage #(
            .WIDTH (WIDTH),
            .DIST  (2 ** k)
        ) u_layer (
            .stage_in  (chain[k]),
            .sel       (core_amt[k]),
            .stage_out (chain[k+1])
        );
    end

    assign core_out = chain[AMT_W];
endmodule

// File: rtl/ring_rotate_right.sv
module ring_rotate_right #(
    parameter int unsigned WIDTH = rot_pkg::ROT_WIDTH,
    parameter int unsigned AMT_W = $clog2(WIDTH)
) (
    input  logic [WIDTH-1:0] din,
    input  logic [AMT_W-1:0] amt,
    output logic [WIDTH-1:0] dout
);
    // position where input bit 0 must appear: (WIDTH - amt) mod WIDTH
    logic [AMT_W-1:0] wrap_pos;
    assign wrap_pos = '0 - amt;

    rot_core #(
        .WIDTH (WIDTH),
        .AMT_W (AMT_W)
    ) u_core (
        .core_in  (din),
        .core_amt (amt),
        .core_out (dout)
    );

    always_comb begin
        if (!$isunknown({din, amt})) begin
            assert_zero_pass_R5: assert (amt != '0 || dout == din)
                else $error("count zero altered the word");
            assert_wrap_lsb_R3: assert (dout[wrap_pos] == din[0])
                else $error("bit 0 did not land at its wrapped position");
            assert_ones_kept_R2: assert ($countones(dout) == $countones(din))
                else $error("rotation changed the count of ones");
            assert_top_msb_R3: assert (amt != AMT_W'(1) || dout[WIDTH-1] == din[0])
                else $error("count one did not move bit 0 to the top");
        end
    end
endmodule

// File: tb/sim_ring_rotate_right.sv
module sim_ring_rotate_right;
    logic        clk = 1'b0;
    logic [15:0] din = '0;
    logic [3:0]  amt = '0;
    logic [15:0] dout;
    int          n_run  = 0;
    int          n_fail = 0;
    bit          done   = 1'b0;

    always #4 clk = ~clk;

    ring_rotate_right u0 (
        .din  (din),
        .amt  (amt),
        .dout (dout)
    );

    function automatic logic [15:0] model(input logic [15:0] a, input int b);
        logic [31:0] twice;
        twice = {a, a};
        return twice[b +: 16];
    endfunction

    task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s din=%h amt=%0d got=%h exp=%h", req, din, amt, got, exp);
        end
    endtask

    task automatic apply(input logic [15:0] a, input int b);
        @(posedge clk);
        #1;
        din = a;
        amt = 4'(b);
        @(negedge clk);
    endtask

    initial begin
        // R9 first value: zero word, zero count
        @(negedge clk);
        check("R9 start", dout, 16'h0000);

        // R6 worked example
        apply(16'hB573, 5);
        check("R6 example", dout, 16'h9DAB);

        // R3 bit 0 wraps to bit 15
        apply(16'h0001, 1);
        check("R3 wrap", dout, 16'h8000);

        for (int b = 0; b < 16; b++) begin
            // R8 edge words
            apply(16'h0000, b);
            check("R8 zeros", dout, 16'h0000);
            apply(16'hFFFF, b);
            check("R8 ones", dout, 16'hFFFF);
            // R3 single-bit words, every position
            for (int p = 0; p < 16; p++) begin
                apply(16'(1) << p, b);
                check("R3 onehot", dout, model(16'(1) << p, b));
            end
        end

        // R5 count zero passes any word
        for (int i = 0; i < 50; i++) begin
            logic [15:0] w;
            w = 16'($urandom);
            apply(w, 0);
            check("R5 zero count", dout, w);
        end

        // R7 each single-bit count turns by its power of two
        for (int k = 0; k < 4; k++) begin
            apply(16'hB573, 1 << k);
            check("R7 layer", dout, model(16'hB573, 1 << k));
        end

        // R1 R4 R2 all counts with random words
        for (int b = 0; b < 16; b++) begin
            for (int i = 0; i < 300; i++) begin
                logic [15:0] w;
                w = 16'($urandom);
                apply(w, b);
                check("R4 formula", dout, 16'((32'(w) >> b) | (32'(w) << (16 - b))));
                n_run++;
                if ($countones(dout) != $countones(w)) begin
                    n_fail++;
                    $display("FAIL R2 ones din=%h amt=%0d got=%0d exp=%0d",
                             w, b, $countones(dout), $countones(w));
                end
            end
        end

        // R9 input change reflected within the same half period
        @(posedge clk);
        #1;
        din = 16'h1234;
        amt = 4'd4;
        #1;
        check("R9 same cycle", dout, 16'h4123);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog got=hung exp=finished");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule